// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block converts a 32-bit virtual address into a 32-bit physical address. It reads one or two 32-bit descriptors from a translation table in memory. A caller passes the virtual address and the table base through a valid/ready handshake. The walker then fetches the first-level descriptor over a single-word memory port. That descriptor either ends the walk, as a section or a fault, or points to a second-level table.

Second-level tables come in two formats. A coarse table is indexed by virtual address bits [19:12]. A fine table is indexed by bits [19:10]. The second-level descriptor then yields a large, small or tiny page. A configuration input can forbid fine tables; with it low, a fine-table pointer counts as a fault.

Each walk ends with a one-cycle done pulse. The pulse carries the physical address, a 2-bit cacheable/bufferable attribute and a fault flag. Access permissions, domains and any caching of results are left to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: The first memory read of a walk goes to address {base[31:14], va[31:20], 2'b00}.
- R2: A first-level descriptor with bits [1:0] = 0 ends the walk with fault = 1, pa = 0 and attr = 0, after exactly one read.
- R3: A first-level descriptor with bits [1:0] = 2 is a section. The walk ends after one read with pa = {desc[31:20], va[19:0]}, attr = desc[3:2] and fault = 0.
- R4: A first-level descriptor with bits [1:0] = 1 is a coarse table. The second read goes to {desc[31:10], va[19:12], 2'b00}.
- R5: A first-level descriptor with bits [1:0] = 3 is a fine table.
  - If the tiny-page input was high when the request was accepted, the second read goes to {desc[31:12], va[19:10], 2'b00}.
  - If that input was low, the walk faults after one read.
  - The input is sampled only at acceptance.
- R6: The second-level descriptor type sets the page size and how pa is formed:
  - bits [1:0] = 1 (large page): pa = {desc[31:16], va[15:0]};
  - bits [1:0] = 2 (small page): pa = {desc[31:12], va[11:0]};
  - bits [1:0] = 3 (tiny page): pa = {desc[31:10], va[9:0]}.
- R7: Every successful second-level mapping reports attr = desc[3:2]. A second-level descriptor with bits [1:0] = 0 faults with pa = 0 and attr = 0.
- R8: A memory response with the error flag set ends the walk with fault = 1, pa = 0 and attr = 0.
- R9: Only one read is outstanding at any time. While mem_req_ready is low, mem_req_valid and mem_req_addr stay unchanged.
- R10: req_ready is low from acceptance until the walk completes. done is high for exactly one cycle per walk.
- R11: A synchronous reset returns the walker to idle. It drops any pending memory request, so req_ready = 1, mem_req_valid = 0 and done = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tiny_en | input | 1 | Fine tables allowed; sampled at request acceptance |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | Translation table base (bits [31:14] used) |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address of the descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read error |
| done | output | 1 | One-cycle result strobe |
| pa | output | 32 | Physical address (zero on fault) |
| attr | output | 2 | Cacheable/bufferable attribute (zero on fault) |
| fault | output | 1 | Translation or bus fault |

## Verification
The walker has no parameters, so the bench builds it as it stands. The bench drives the tiny-page input both high and low, which covers both the fine-table path and its fault. The bench's memory model can stall request acceptance for several cycles and can flag an error on a chosen address. Together these cover the held-request rule, the bus-error fault, and a reset that arrives while a read is outstanding.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst,
  input  logic        tiny_en,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [31:0] req_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        done,
  output logic [31:0] pa,
  output logic [1:0]  attr,
  output logic        fault
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_t;

  walk_st_t    st;
  logic [31:0] va_q;
  logic [31:0] addr_q;
  logic        tiny_q;
  logic [1:0]  kind;

  assign kind          = mem_rsp_data[1:0];
  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
  assign mem_req_addr  = addr_q;
  assign done          = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      va_q   <= '0;
      addr_q <= '0;
      tiny_q <= 1'b0;
      pa     <= '0;
      attr   <= '0;
      fault  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_va;
          tiny_q <= tiny_en;
          addr_q <= {req_base[31:14], req_va[31:20], 2'b00};
          st     <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready) st <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err || kind == 2'd0 || (kind == 2'd3 && !tiny_q)) begin
            pa    <= '0;
            attr  <= '0;
            fault <= 1'b1;
            st    <= ST_DONE;
          end else if (kind == 2'd2) begin
            pa    <= {mem_rsp_data[31:20], va_q[19:0]};
            attr  <= mem_rsp_data[3:2];
            fault <= 1'b0;
            st    <= ST_DONE;
          end else if (kind == 2'd1) begin
            addr_q <= {mem_rsp_data[31:10], va_q[19:12], 2'b00};
            st     <= ST_L2_REQ;
          end else begin
            addr_q <= {mem_rsp_data[31:12], va_q[19:10], 2'b00};
            st     <= ST_L2_REQ;
          end
        end
        ST_L2_REQ: if (mem_req_ready) st <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          st <= ST_DONE;
          if (mem_rsp_err || kind == 2'd0) begin
            pa    <= '0;
            attr  <= '0;
            fault <= 1'b1;
          end else begin
            attr  <= mem_rsp_data[3:2];
            fault <= 1'b0;
            case (kind)
              2'd1:    pa <= {mem_rsp_data[31:16], va_q[15:0]};
              2'd2:    pa <= {mem_rsp_data[31:12], va_q[11:0]};
              default: pa <= {mem_rsp_data[31:10], va_q[9:0]};
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_NO_REQ_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_L1_WAIT || st == ST_L2_WAIT) |-> !mem_req_valid); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready); // R10
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    done && fault |-> pa == 32'd0 && attr == 2'd0); // R2
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> req_ready && !mem_req_valid && !done); // R11

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tiny_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] req_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        done;
  logic [31:0] pa;
  logic [1:0]  attr;
  logic        fault;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] log_a [0:7];
  int          reads = 0;
  int          stall = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic        pend = 1'b0;
  logic [31:0] pend_a = '0;
  logic [31:0] stall_a = '0;

  pt_walker u_dut (
    .clk(clk), .rst(rst), .tiny_en(tiny_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_base(req_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .done(done), .pa(pa), .attr(attr), .fault(fault)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst) begin
      pend = 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_req_ready <= 1'b1;
    end else begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      mem_req_ready <= 1'b1;
      if (pend) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(pend_a) ? mem[pend_a] : 32'd0;
        mem_rsp_err   <= err_en && (pend_a == err_addr);
        if (reads < 8) log_a[reads] = pend_a;
        reads = reads + 1;
        pend = 1'b0;
      end else if (mem_req_valid) begin
        if (stall > 0) begin
          stall_a = mem_req_addr;
          stall = stall - 1;
          mem_req_ready <= 1'b0;
        end else begin
          pend = 1'b1;
          pend_a = mem_req_addr;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] l1_addr(input logic [31:0] b, input logic [31:0] v);
    return (b & 32'hFFFF_C000) | ((v & 32'hFFF0_0000) >> 18);
  endfunction

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic ten,
                      input bit drop_ten, output logic [31:0] r_pa, output logic [1:0] r_attr,
                      output logic r_fault);
    int n = 0;
    @(negedge clk);
    reads = 0;
    req_va = va; req_base = base; tiny_en = ten; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (drop_ten) tiny_en = ~ten;
    chk(req_ready == 1'b0, "R10 busy", {31'd0, req_ready}, 32'd0);
    while (!done && n < 60) begin @(negedge clk); n++; end
    r_pa = pa; r_attr = attr; r_fault = fault;
    chk(done == 1'b1, "R10 done seen", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", {31'd0, done}, 32'd0);
    chk(req_ready == 1'b1, "R10 ready after", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_reset_state;
    chk(req_ready == 1'b1, "R11 ready at reset", {31'd0, req_ready}, 32'd1);
    chk(mem_req_valid == 1'b0 && done == 1'b0, "R11 idle at reset", {30'd0, mem_req_valid, done}, 32'd0);
  endtask

  task automatic t_l1_fault;
    logic [31:0] p; logic [1:0] a; logic f;
    logic [31:0] va = 32'hC0DE_1234, b = 32'h1234_8000;
    mem.delete();
    mem[l1_addr(b, va)] = 32'hFFFF_FFFC;
    walk(va, b, 1'b1, 0, p, a, f);
    chk(log_a[0] == l1_addr(b, va), "R1 L1 address", log_a[0], l1_addr(b, va));
    chk(f == 1'b1 && p == 0 && a == 0, "R2 L1 type0 fault", p, 32'd0);
    chk(reads == 1, "R2 one read", reads, 1);
  endtask

  task automatic t_section(input int stall_n);
    logic [31:0] p; logic [1:0] a; logic f;
    logic [31:0] va = 32'h0123_4567, b = 32'hFEDC_7FFF, d = 32'hABC0_000A;
    mem.delete();
    mem[l1_addr(b, va)] = d;
    stall = stall_n;
    walk(va, b, 1'b0, 0, p, a, f);
    chk(log_a[0] == l1_addr(b, va), "R1 L1 address section", log_a[0], l1_addr(b, va));
    chk(f == 0 && p == 32'hABC3_4567, "R3 section pa", p, 32'hABC3_4567);
    chk(a == 2'b10, "R3 section attr", a, 2'b10);
    chk(reads == 1, "R3 single read", reads, 1);
    if (stall_n > 0)
      chk(stall_a == log_a[0], "R9 held addr under stall", stall_a, log_a[0]);
  endtask

  task automatic t_coarse(input logic [31:0] d2, input logic [31:0] exp_pa, input logic [1:0] exp_attr,
                          input string tag);
    logic [31:0] p; logic [1:0] a; logic f;
    logic [31:0] va = 32'h7FAB_CDEF, b = 32'h0002_4000, d1 = 32'h0040_0401;
    logic [31:0] l2 = (d1 & 32'hFFFF_FC00) | ((va & 32'h000F_F000) >> 10);
    mem.delete();
    mem[l1_addr(b, va)] = d1;
    mem[l2] = d2;
    walk(va, b, 1'b0, 0, p, a, f);
    chk(log_a[1] == l2, "R4 coarse L2 address", log_a[1], l2);
    chk(f == 0 && p == exp_pa, tag, p, exp_pa);
    chk(a == exp_attr, "R7 L2 attr", a, exp_attr);
  endtask

  task automatic t_fine(input logic ten, input bit drop);
    logic [31:0] p; logic [1:0] a; logic f;
    logic [31:0] va = 32'h3456_7ABC, b = 32'h8000_0000, d1 = 32'h0080_1003, d2 = 32'h9999_9C07;
    logic [31:0] l2 = (d1 & 32'hFFFF_F000) | ((va & 32'h000F_FC00) >> 8);
    logic [31:0] ep = (d2 & 32'hFFFF_FC00) | (va & 32'h3FF);
    mem.delete();
    mem[l1_addr(b, va)] = d1;
    mem[l2] = d2;
    walk(va, b, ten, drop, p, a, f);
    if (ten) begin
      chk(log_a[1] == l2, "R5 fine L2 address", log_a[1], l2);
      chk(f == 0 && p == ep, "R6 tiny page pa", p, ep);
      chk(a == 2'b01, "R7 tiny attr", a, 2'b01);
    end else begin
      chk(f == 1 && p == 0 && a == 0, "R5 fine disabled fault", {31'd0, f}, 32'd1);
      chk(reads == 1, "R5 no second read", reads, 1);
    end
  endtask

  task automatic t_l2_bad(input bit use_err);
    logic [31:0] p; logic [1:0] a; logic f;
    logic [31:0] va = 32'h0011_2233, b = 32'h0000_C000, d1 = 32'h0040_0801;
    logic [31:0] l2 = (d1 & 32'hFFFF_FC00) | ((va & 32'h000F_F000) >> 10);
    mem.delete();
    mem[l1_addr(b, va)] = d1;
    mem[l2] = use_err ? 32'h1234_500E : 32'h1234_500C;
    err_en = use_err; err_addr = l2;
    walk(va, b, 1'b0, 0, p, a, f);
    err_en = 1'b0;
    if (use_err)
      chk(f == 1 && p == 0 && a == 0, "R8 error response fault", p, 32'd0);
    else
      chk(f == 1 && p == 0 && a == 0, "R7 L2 type0 fault", p, 32'd0);
    chk(reads == 2, "R9 two reads", reads, 2);
  endtask

  task automatic t_reset_mid;
    logic [31:0] va = 32'h0123_4567, b = 32'h0000_4000;
    mem.delete();
    mem[l1_addr(b, va)] = 32'h0040_0401;
    stall = 5;
    @(negedge clk);
    req_va = va; req_base = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(mem_req_valid == 1'b1, "R9 request held in stall", {31'd0, mem_req_valid}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk(mem_req_valid == 1'b0 && req_ready == 1'b1 && done == 1'b0, "R11 reset mid walk",
        {29'd0, mem_req_valid, req_ready, done}, 32'd2);
    stall = 0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    t_l1_fault();
    t_section(0);
    t_section(3);
    t_coarse(32'h5555_6006, 32'h5555_6DEF, 2'b01, "R6 small page pa");
    t_coarse(32'h7777_000D, 32'h7777_CDEF, 2'b11, "R6 large page pa");
    t_coarse(32'hAAAA_A80B, 32'hAAAA_A9EF, 2'b10, "R6 tiny via coarse pa");
    t_fine(1'b1, 1'b1);
    t_fine(1'b0, 1'b1);
    t_l2_bad(1'b0);
    t_l2_bad(1'b1);
    t_reset_mid();
    t_section(0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule